// File: doc/BRIEF.md
# Serial Converter Read Master

This block is the host side of a three-wire exchange with an 8-bit successive-approximation converter. The block takes a one-cycle request that carries a 2-bit channel/mode code. It then drives chip select low and generates a serial clock divided down from the system clock. On data-in it sends a start bit and the two code bits, then releases that line.

The converter returns a leading zero, then the result MSB first, then a bit-reversed copy without its LSB. The block drops the zero slot and captures both streams on the rising serial clock edge, because the converter changes its output on the falling edge. It returns the MSB-first value as the result, with a one-cycle valid pulse. A mismatch flag reports whether the reversed copy disagreed.

The half-period of the serial clock is a parameter. Choose it so that the serial clock stays within the converter's 10 kHz to 2 MHz limit. The clock always has a 50% duty cycle.

Top module: `serial_adc_host`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0, valid is 0 and sdo_oe is 0.
- R2: A clock edge that samples req high while busy is low makes busy high and cs_n low after that edge. The mode value is captured at that same edge.
- R3: While cs_n is low, sclk starts low, and every low phase and every high phase lasts exactly DIV_HALF clock cycles. One exchange has exactly 2*DATA_W+3 rising sclk edges (19 at the default width). sclk is 0 whenever cs_n is 1.
- R4: At rising sclk edges 1, 2 and 3, sdo_oe is 1 and sdo carries, in order, a 1 (start), then mode[1], then mode[0]. mode[1]=1 selects single-ended; mode[1]=0 selects differential. mode[0] picks the channel or the polarity. sdo_oe is 0 from the falling edge after rise 3, and is never 1 while cs_n is 1.
- R5: The value sampled from sdi at rise 4 is discarded. result holds the bits sampled at rises 5 to DATA_W+4, with the first one in the MSB.
- R6: The bits sampled at rises DATA_W+5 to 2*DATA_W+3 are result bits 1 to DATA_W-1, in that order. mismatch is 1 exactly when any of them differs from the matching bit of the MSB-first value.
- R7: valid is a one-cycle pulse. busy is 0 in the valid cycle, and busy falls only in a valid cycle.
- R8: A request that arrives while busy is high has no effect. It does not change the mode sent, the result, or the number of exchanges.
- R9: cs_n rises at the end of the high phase of the last rising edge. valid appears at the 2*DIV_HALF-th clock edge after the edge that raised cs_n.
- R10: result and mismatch change only in a cycle in which valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start one conversion |
| mode | input | 2 | Channel/mode code; bit 1 selects single-ended, bit 0 picks channel or polarity |
| busy | output | 1 | Exchange in progress |
| valid | output | 1 | One-cycle pulse when result is updated |
| result | output | DATA_W | MSB-first conversion value |
| mismatch | output | 1 | Reversed copy disagreed with result |
| cs_n | output | 1 | Chip select to converter, active low |
| sclk | output | 1 | Divided serial clock |
| sdo | output | 1 | Data toward converter input |
| sdo_oe | output | 1 | Drive enable for sdo |
| sdi | input | 1 | Data from converter output |

## Verification
The assertions check the following on every cycle:
- sclk stays low and the data line is released whenever chip select is high.
- An accepted request pulls chip select low at once.
- valid is a single pulse that coincides with busy falling.
- result and mismatch never change outside a valid pulse.

Some properties depend on the serial content of an exchange, and only the bench scenarios show them. These are the start and code bits the converter model receives at its rising edges, the skipping of the zero slot, and the comparison against the reversed copy, including a deliberately corrupted copy. The same holds for the exact half-period widths, the rising-edge count, the chip-select gap before valid, and the discarding of requests made during an exchange.

// File: rtl/serial_adc_host.sv
module serial_adc_host #(
  parameter int DIV_HALF = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        mode,
  output logic              busy,
  output logic              valid,
  output logic [DATA_W-1:0] result,
  output logic              mismatch,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi
);

  localparam int PW     = $clog2(DIV_HALF + 1);
  localparam int RISES  = 2 * DATA_W + 3;
  localparam int HALVES = 2 * RISES;
  localparam int HW     = $clog2(HALVES + 1);
  localparam int GAP    = 2 * DIV_HALF;
  localparam int GW     = $clog2(GAP + 1);
  localparam int MSB_LO = 5;
  localparam int MSB_HI = DATA_W + 4;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;

  st_t               st;
  logic [PW-1:0]     ph;
  logic [HW-1:0]     hc;
  logic [GW-1:0]     gc;
  logic [1:0]        mode_q;
  logic [DATA_W-1:0] msb_q;
  logic [DATA_W-2:0] lsb_q;
  logic              valid_q;

  logic              tick;
  logic              rise;
  logic [HW-1:0]     rk;

  assign tick = (ph == PW'(DIV_HALF - 1));
  assign rise = (st == S_RUN) && tick && !hc[0];
  assign rk   = (hc >> 1) + HW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= '0;
      hc       <= '0;
      gc       <= '0;
      mode_q   <= '0;
      msb_q    <= '0;
      lsb_q    <= '0;
      result   <= '0;
      mismatch <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req) begin
            mode_q <= mode;
            st     <= S_RUN;
            ph     <= '0;
            hc     <= '0;
          end
        end
        S_RUN: begin
          if (tick) begin
            ph <= '0;
            if (hc == HW'(HALVES - 1)) begin
              st <= S_GAP;
              gc <= '0;
            end else begin
              hc <= hc + HW'(1);
            end
            if (rise && rk >= HW'(MSB_LO) && rk <= HW'(MSB_HI))
              msb_q <= {msb_q[DATA_W-2:0], sdi};
            if (rise && rk > HW'(MSB_HI))
              lsb_q <= {sdi, lsb_q[DATA_W-2:1]};
          end else begin
            ph <= ph + PW'(1);
          end
        end
        S_GAP: begin
          if (gc == GW'(GAP - 1)) begin
            st       <= S_IDLE;
            valid_q  <= 1'b1;
            result   <= msb_q;
            mismatch <= (lsb_q != msb_q[DATA_W-1:1]);
          end else begin
            gc <= gc + GW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign valid  = valid_q;
  assign cs_n   = (st != S_RUN);
  assign sclk   = (st == S_RUN) && hc[0];
  assign sdo_oe = (st == S_RUN) && (hc < HW'(6));
  assign sdo    = (hc < HW'(2)) ? 1'b1 : (hc < HW'(4)) ? mode_q[1] : mode_q[0];

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_oe_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !cs_n);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> (busy && !cs_n));
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !busy);
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> valid);
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> valid);
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mismatch) |-> valid);

endmodule

// File: tb/serial_adc_host_bench.sv
module serial_adc_host_bench;
  localparam int CLK_P    = 10;
  localparam int DIV_HALF = 4;
  localparam int DATA_W   = 8;
  localparam int RISES    = 2 * DATA_W + 3;

  logic clk = 0;
  logic rst_n = 0;
  logic req = 0;
  logic [1:0] mode = 0;
  logic busy, valid, mismatch, cs_n, sclk, sdo, sdo_oe;
  logic [DATA_W-1:0] result;
  logic sdi = 0;

  int total = 0;
  int bad = 0;
  int done_cnt = 0;
  int sent_cnt = 0;

  logic [7:0] ch0 = 0, ch1 = 0;
  bit corrupt = 0;
  bit m_start = 0;
  bit m_oe_ok = 0;
  bit m_rel_ok = 0;
  logic [1:0] m_addr = 0;

  typedef struct packed { logic [7:0] code; logic flag; logic [1:0] md; } exp_t;
  exp_t q[$];

  serial_adc_host #(.DIV_HALF(DIV_HALF), .DATA_W(DATA_W)) u_serial_adc_host (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .busy(busy),
    .valid(valid), .result(result), .mismatch(mismatch), .cs_n(cs_n),
    .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] conv(input logic [1:0] m, input logic [7:0] a,
                                      input logic [7:0] b);
    case (m)
      2'b10: return a;
      2'b11: return b;
      2'b00: return (a > b) ? a - b : 8'd0;
      default: return (b > a) ? b - a : 8'd0;
    endcase
  endfunction

  // converter model
  initial begin
    forever begin
      logic [7:0] c;
      @(negedge cs_n);
      @(posedge sclk); m_start = sdo; m_oe_ok = sdo_oe;
      @(posedge sclk); m_addr[1] = sdo; m_oe_ok = m_oe_ok & sdo_oe;
      @(posedge sclk); m_addr[0] = sdo; m_oe_ok = m_oe_ok & sdo_oe;
      c = conv(m_addr, ch0, ch1);
      @(negedge sclk); sdi = 1'b0;
      #1 m_rel_ok = !sdo_oe;
      for (int i = 7; i >= 0; i--) begin
        @(negedge sclk); sdi = c[i];
      end
      for (int i = 1; i <= 7; i++) begin
        @(negedge sclk); sdi = c[i] ^ (corrupt && i == 3);
      end
      @(posedge cs_n); sdi = 1'b0;
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (valid) begin
        exp_t e;
        done_cnt++;
        if (q.size() == 0) begin
          chk(0, "R8", "unexpected result", done_cnt, sent_cnt);
        end else begin
          e = q.pop_front();
          chk(result == e.code, "R5", "result", result, e.code);
          chk(mismatch == e.flag, "R6", "mismatch", mismatch, e.flag);
          chk(m_start && m_oe_ok && m_addr == e.md, "R4", "start/addr seen",
              {m_start, m_oe_ok, m_addr}, {2'b11, e.md});
          chk(m_rel_ok, "R4", "release after rise 3", m_rel_ok, 1);
          chk(!busy, "R7", "busy in valid cycle", busy, 0);
        end
      end
    end
  end

  // serial clock timing monitor
  initial begin
    bit in_x = 0, prev = 0, terr = 0, gap_on = 0;
    int run = 0, rises = 0, g = 0;
    forever begin
      @(negedge clk);
      if (!cs_n) begin
        if (!in_x) begin
          in_x = 1; prev = sclk; run = 1; rises = 0; terr = sclk;
        end else if (sclk == prev) begin
          run++;
        end else begin
          if (run != DIV_HALF) terr = 1;
          if (sclk) rises++;
          prev = sclk; run = 1;
        end
      end else begin
        if (sclk) terr = 1;
        if (in_x) begin
          if (run != DIV_HALF || !prev) terr = 1;
          chk(!terr, "R3", "half-period widths", run, DIV_HALF);
          chk(rises == RISES, "R3", "rising edge count", rises, RISES);
          in_x = 0; gap_on = 1; g = 0;
        end
        if (gap_on) begin
          g++;
          if (valid) begin
            chk(g == 2 * DIV_HALF + 1, "R9", "cs_n high to valid", g - 1, 2 * DIV_HALF);
            gap_on = 0;
          end
        end
      end
    end
  end

  task automatic run_conv(input logic [1:0] md, input logic [7:0] a,
                          input logic [7:0] b, input bit bad_copy);
    exp_t e;
    int target;
    ch0 = a; ch1 = b; corrupt = bad_copy;
    e.code = conv(md, a, b);
    e.flag = bad_copy;
    e.md = md;
    q.push_back(e);
    sent_cnt++;
    target = done_cnt + 1;
    @(negedge clk); req = 1; mode = md;
    @(negedge clk); req = 0;
    chk(busy && !cs_n, "R2", "accept", {busy, cs_n}, 2);
    wait (done_cnt == target);
    @(negedge clk);
    chk(!valid, "R7", "valid one cycle", valid, 0);
  endtask

  initial begin
    logic [7:0] held;
    #(CLK_P * 3);
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !valid && !sdo_oe, "R1", "reset outputs",
        {cs_n, sclk, busy, valid, sdo_oe}, 5'b10000);
    rst_n = 1;
    repeat (3) @(negedge clk);

    run_conv(2'b10, 8'hA5, 8'h11, 0);
    run_conv(2'b11, 8'h07, 8'h3C, 0);
    run_conv(2'b00, 8'h90, 8'h30, 0);
    run_conv(2'b01, 8'h90, 8'h30, 0);
    run_conv(2'b10, 8'hFF, 8'h00, 0);
    run_conv(2'b11, 8'hFF, 8'h00, 0);
    run_conv(2'b10, 8'h5A, 8'h00, 1);

    // R8: requests during an exchange are discarded
    begin
      exp_t e;
      ch0 = 8'h81; ch1 = 8'h42; corrupt = 0;
      e.code = 8'h81; e.flag = 0; e.md = 2'b10;
      q.push_back(e); sent_cnt++;
      @(negedge clk); req = 1; mode = 2'b10;
      @(negedge clk); req = 0;
      repeat (20) @(negedge clk);
      req = 1; mode = 2'b11;
      @(negedge clk); req = 0;
      repeat (40) @(negedge clk);
      req = 1; mode = 2'b01;
      @(negedge clk); req = 0;
      wait (done_cnt == sent_cnt);
      repeat (60) @(negedge clk);
      chk(done_cnt == 8 && !busy && cs_n, "R8", "no extra exchange",
          done_cnt, 8);
    end

    // R10: result held while idle and during the next exchange
    held = result;
    ch0 = 8'h33; corrupt = 0;
    @(negedge clk); req = 1; mode = 2'b10;
    @(negedge clk); req = 0;
    repeat (50) @(negedge clk);
    chk(result == held && !mismatch, "R10", "result held mid-exchange", result, held);
    begin
      exp_t e;
      e.code = 8'h33; e.flag = 0; e.md = 2'b10;
      q.push_back(e); sent_cnt++;
    end
    wait (done_cnt == sent_cnt);
    repeat (5) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, sent_cnt);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule